// File: doc/BRIEF.md
# Sub-word register write merge unit

This block is a 64-bit general-purpose register file with one write port and two read ports. A write carries a register index, a size code and a data word. The size code decides two things. It sets which low bytes take new data. It also sets whether the bytes above them keep their old contents or become zero. Byte and halfword writes keep the upper bits. Word writes zero-extend and full writes replace the whole register, so neither of them depends on the old value.

Each register has a pending bit that marks a write still in flight. An accepted write sets the bit, and a completion strobe that names the register clears it. A merging write (byte or halfword) aimed at a pending register cannot take its old upper bits yet. The unit raises a combinational stall instead of applying that write. The requester holds the request until the stall drops. Word and full writes never wait, because they do not read the old contents.

Top module: `srw_merge_top`

## Requirements
- R1: After reset every register reads zero and no register is pending, so a byte write to any register is accepted at once.
- R2: A write with size code 2'b00 puts wr_data[7:0] into bits 7:0 of the target and keeps bits 63:8. Data bits above bit 7 are ignored.
- R3: A write with size code 2'b01 puts wr_data[15:0] into bits 15:0 and keeps bits 63:16.
- R4: A write with size code 2'b10 puts wr_data[31:0] into bits 31:0 and forces bits 63:32 to zero.
- R5: A write with size code 2'b11 replaces all 64 bits with wr_data.
- R6: An accepted write sets the target's pending bit. A completion strobe with a matching index clears it. When an accepted write and a completion name the same register in the same cycle, the register stays pending.
- R7: wr_stall is high, in the same cycle and with no register in the path, exactly when wr_valid is high, the size code is 2'b00 or 2'b01, and the target register is pending.
- R8: Writes with size code 2'b10 or 2'b11 never stall, even when the target is pending.
- R9: A stalled write changes neither the register contents nor any pending bit.
- R10: Both read ports are combinational and independent. A read of the register being written in the same cycle returns the value from before the write.
- R11: A completion for one register leaves the pending bits of all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request present |
| wr_idx | input | IDX_W | Target register of the write |
| wr_size | input | 2 | Size code: 00 byte, 01 halfword, 10 word, 11 full |
| wr_data | input | DATA_W | Write data, right-aligned |
| cmp_valid | input | 1 | Completion strobe for an in-flight write |
| cmp_idx | input | IDX_W | Register whose in-flight write completes |
| rd_a_idx | input | IDX_W | Read port A index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | IDX_W | Read port B index |
| rd_b_data | output | DATA_W | Read port B data |
| wr_stall | output | 1 | Write must be held; it is not applied this cycle |

## Verification
The first patterns write the same register with each size code in turn, using data that has all-ones upper bytes. These runs show whether the unit keeps the upper bits or zero-extends them, and whether it takes too many or too few low bytes. Next, a byte write is held against a pending register across several cycles and then released by a completion. This shows whether the stall blocks both the data and the pending update. Word and full writes sent to a pending register show whether the unit stalls only the merging sizes. A completion that lands together with a new write to the same register, and completions aimed at other registers, show the ordering of set and clear on the pending bits. A long stretch of mixed traffic over four registers compares both read ports and the stall against the reference model. Because reads and writes often hit the same register in the same cycle, this traffic also shows whether a read returns the value from before or after the write.

// File: rtl/srw_pkg.sv
`timescale 1ns/1ps
package srw_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_FULL = 2'b11
  } srw_size_e;

  // Byte and halfword writes keep the old upper bits, so they depend on the previous writer.
  function automatic logic size_merges(input srw_size_e sz);
    return (sz == SZ_BYTE) || (sz == SZ_HALF);
  endfunction

  // Word writes zero the bytes above the written lanes.
  function automatic logic size_zero_ext(input srw_size_e sz);
    return sz == SZ_WORD;
  endfunction

  // Number of byte lanes carrying new data.
  function automatic int unsigned size_lanes(input srw_size_e sz);
    return 32'd1 << sz;
  endfunction

endpackage

// File: rtl/srw_lane_merge.sv
`timescale 1ns/1ps
module srw_lane_merge
  import srw_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] new_val,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] merged
);
  localparam int NBYTES = DATA_W / 8;

  srw_size_e   sz;
  logic        zext;
  int unsigned lanes;

  always_comb begin
    sz    = srw_size_e'(size);
    zext  = size_zero_ext(sz);
    lanes = size_lanes(sz);
  end

  // One selector per byte lane: new data, zero or old contents.
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic take_new;
    always_comb begin
      take_new = (b < lanes);
      if (take_new)  merged[b*8 +: 8] = new_val[b*8 +: 8];
      else if (zext) merged[b*8 +: 8] = 8'h00;
      else           merged[b*8 +: 8] = old_val[b*8 +: 8];
    end
  end

endmodule

// File: rtl/srw_pending_board.sv
`timescale 1ns/1ps
module srw_pending_board #(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_idx,
  output logic [NUM_REGS-1:0] pend_q
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
    logic hit_set;
    logic hit_clr;
    assign hit_set = set_en && (set_idx == IDX_W'(i));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(i));

    // A new issue wins over a completion that arrives in the same cycle.
    always_ff @(posedge clk) begin
      if (rst)          pend_q[i] <= 1'b0;
      else if (hit_set) pend_q[i] <= 1'b1;
      else if (hit_clr) pend_q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/srw_regfile_store.sv
`timescale 1ns/1ps
module srw_regfile_store #(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int NUM_RD   = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [IDX_W-1:0]              waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NUM_RD-1:0][IDX_W-1:0]  raddr,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Asynchronous read ports see the array contents before this cycle's write.
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end

endmodule

// File: rtl/srw_merge_top.sv
`timescale 1ns/1ps
module srw_merge_top
  import srw_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  output logic              wr_stall
);
  localparam int NUM_RD = 3;
  localparam int PORT_A = 0;
  localparam int PORT_B = 1;
  localparam int PORT_M = 2;

  logic [NUM_REGS-1:0]            pend_q;
  logic [NUM_RD-1:0][IDX_W-1:0]   raddr;
  logic [NUM_RD-1:0][DATA_W-1:0]  rdata;
  logic [DATA_W-1:0]              merged;
  logic                           needs_old;
  logic                           accept;

  assign needs_old = size_merges(srw_size_e'(wr_size));
  assign wr_stall  = wr_valid && needs_old && pend_q[wr_idx];
  assign accept    = wr_valid && !wr_stall;

  always_comb begin
    raddr[PORT_A] = rd_a_idx;
    raddr[PORT_B] = rd_b_idx;
    raddr[PORT_M] = wr_idx;
  end

  srw_regfile_store #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NUM_RD(NUM_RD)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (accept),
    .waddr (wr_idx),
    .wdata (merged),
    .raddr (raddr),
    .rdata (rdata)
  );

  srw_lane_merge #(.DATA_W(DATA_W)) u_merge (
    .old_val (rdata[PORT_M]),
    .new_val (wr_data),
    .size    (wr_size),
    .merged  (merged)
  );

  srw_pending_board #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_en  (accept),
    .set_idx (wr_idx),
    .clr_en  (cmp_valid),
    .clr_idx (cmp_idx),
    .pend_q  (pend_q)
  );

  assign rd_a_data = rdata[PORT_A];
  assign rd_b_data = rdata[PORT_B];

endmodule

// File: rtl/srw_merge_chk.sv
`timescale 1ns/1ps
module srw_merge_chk #(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_valid,
  input logic [IDX_W-1:0]    wr_idx,
  input logic [1:0]          wr_size,
  input logic                cmp_valid,
  input logic [IDX_W-1:0]    cmp_idx,
  input logic [DATA_W-1:0]   rd_a_data,
  input logic                wr_stall,
  input logic [NUM_REGS-1:0] pend_q
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pend_q == '0) && (rd_a_data == '0));

  assert_stall_only_merging_R7: assert property (@(posedge clk) disable iff (rst)
    wr_stall |-> (wr_valid && !wr_size[1]));

  assert_wide_never_stalls_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_size[1]) |-> !wr_stall);

  assert_issue_sets_pending_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_stall) |=> pend_q[$past(wr_idx)]);

  assert_complete_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !(wr_valid && !wr_stall && wr_idx == cmp_idx))
      |=> !pend_q[$past(cmp_idx)]);

  assert_stall_keeps_pending_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_stall && !cmp_valid) |=> $stable(pend_q));

  assert_idle_keeps_pending_R11: assert property (@(posedge clk) disable iff (rst)
    (!wr_valid && !cmp_valid) |=> $stable(pend_q));

endmodule

bind srw_merge_top srw_merge_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_valid  (wr_valid),
  .wr_idx    (wr_idx),
  .wr_size   (wr_size),
  .cmp_valid (cmp_valid),
  .cmp_idx   (cmp_idx),
  .rd_a_data (rd_a_data),
  .wr_stall  (wr_stall),
  .pend_q    (pend_q)
);

// File: tb/srw_merge_top_test.sv
`timescale 1ns/1ps
module srw_merge_top_test;
  localparam int DATA_W   = 64;
  localparam int NUM_REGS = 16;
  localparam int IDX_W    = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_valid = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [1:0]        wr_size = 2'b00;
  logic [DATA_W-1:0] wr_data = '0;
  logic              cmp_valid = 1'b0;
  logic [IDX_W-1:0]  cmp_idx = '0;
  logic [IDX_W-1:0]  rd_a_idx = '0;
  logic [DATA_W-1:0] rd_a_data;
  logic [IDX_W-1:0]  rd_b_idx = '0;
  logic [DATA_W-1:0] rd_b_data;
  logic              wr_stall;

  always #10 clk = ~clk;

  srw_merge_top #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_data(wr_data), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx),
    .rd_b_data(rd_b_data), .wr_stall(wr_stall)
  );

  logic [63:0] ref_mem [NUM_REGS];
  bit          ref_pend [NUM_REGS];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  function automatic logic [63:0] model_merge(input logic [63:0] o, input logic [63:0] d,
                                              input logic [1:0] s);
    case (s)
      2'b00:   return {o[63:8], d[7:0]};
      2'b01:   return {o[63:16], d[15:0]};
      2'b10:   return {32'h0, d[31:0]};
      default: return d;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Inputs are set before the call, at the falling edge. Outputs are sampled 4 ns later,
  // and then the model is advanced at the rising edge.
  task automatic step(input string tag_s, input string tag_r);
    bit exp_stall;
    bit acc;
    #4;
    exp_stall = wr_valid && !wr_size[1] && ref_pend[wr_idx];
    check(tag_s, "stall", 64'(wr_stall), 64'(exp_stall));
    check(tag_r, "read A", rd_a_data, ref_mem[rd_a_idx]);
    check(tag_r, "read B", rd_b_data, ref_mem[rd_b_idx]);
    acc = wr_valid && !exp_stall;
    @(posedge clk);
    if (acc) begin
      ref_mem[wr_idx]  = model_merge(ref_mem[wr_idx], wr_data, wr_size);
      ref_pend[wr_idx] = 1'b1;
    end
    if (cmp_valid && !(acc && cmp_idx == wr_idx)) ref_pend[cmp_idx] = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle();
    wr_valid = 1'b0;
    cmp_valid = 1'b0;
  endtask

  task automatic wr(input int r, input logic [1:0] s, input logic [63:0] d);
    wr_valid = 1'b1;
    wr_idx = IDX_W'(r);
    wr_size = s;
    wr_data = d;
    cmp_valid = 1'b0;
  endtask

  task automatic cmp(input int r);
    cmp_valid = 1'b1;
    cmp_idx = IDX_W'(r);
  endtask

  task automatic rd(input int a, input int b);
    rd_a_idx = IDX_W'(a);
    rd_b_idx = IDX_W'(b);
  endtask

  initial begin
    for (int i = 0; i < NUM_REGS; i++) begin
      ref_mem[i] = '0;
      ref_pend[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: every register reads zero after reset
    for (int i = 0; i < NUM_REGS; i += 2) begin
      rd(i, i + 1);
      step("R1", "R1");
    end
    // R1: no register is pending, so a byte write is accepted at once
    wr(7, 2'b00, 64'h5A); rd(7, 7); step("R1", "R1");
    idle(); cmp(7); step("R6", "R2");

    // R5: full write, then complete it
    wr(3, 2'b11, 64'h1122_3344_5566_7788); rd(3, 3); step("R8", "R10");
    idle(); cmp(3); step("R6", "R5");
    // R2: byte write keeps the upper bits and ignores data above bit 7
    wr(3, 2'b00, 64'hFFFF_FFFF_FFFF_FFAA); step("R7", "R5");
    idle(); cmp(3); step("R6", "R2");
    // R3: halfword write
    wr(3, 2'b01, 64'hFFFF_FFFF_FFFF_BEEF); step("R7", "R2");
    idle(); cmp(3); step("R6", "R3");
    // R4: word write zero-extends
    wr(3, 2'b10, 64'hFFFF_FFFF_CAFE_F00D); step("R8", "R3");
    idle(); cmp(3); step("R6", "R4");

    // R7 / R9: byte write to a pending register stalls and is held
    wr(5, 2'b11, 64'h0123_4567_89AB_CDEF); rd(5, 3); step("R8", "R10");
    wr(5, 2'b00, 64'h77); step("R7", "R9");
    step("R7", "R9");
    wr(5, 2'b01, 64'h9999); step("R7", "R9");
    // R11: completion for another register does not release register 5
    wr(5, 2'b00, 64'h77); cmp(3); step("R11", "R9");
    wr(5, 2'b00, 64'h77); step("R11", "R9");
    // The completion for register 5 releases the held write on the next cycle
    wr(5, 2'b00, 64'h77); cmp(5); step("R7", "R9");
    cmp_valid = 1'b0; step("R7", "R9");
    // R8: word and full writes to a pending register go through
    wr(5, 2'b10, 64'hAAAA_BBBB_1234_5678); step("R8", "R4");
    wr(5, 2'b11, 64'hDEAD_BEEF_0BAD_F00D); step("R8", "R5");
    // R6: completion and new write to the same register in one cycle leave it pending
    wr(5, 2'b11, 64'h0F0F_0F0F_0F0F_0F0F); cmp(5); step("R8", "R6");
    wr(5, 2'b00, 64'h11); step("R6", "R9");
    idle(); cmp(5); step("R6", "R6");
    wr(5, 2'b00, 64'h11); step("R6", "R2");
    idle(); cmp(5); step("R6", "R2");

    // Mixed traffic over four registers, checked every cycle
    for (int n = 0; n < 600; n++) begin
      wr_valid  = ($urandom % 4) != 0;
      wr_idx    = IDX_W'($urandom % 4);
      wr_size   = 2'($urandom);
      wr_data   = {$urandom, $urandom};
      cmp_valid = ($urandom % 3) == 0;
      cmp_idx   = IDX_W'($urandom % 4);
      rd($urandom % 4, $urandom % 4);
      step("R7", "R10");
    end
    idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule